// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a bank of byte-wide registers through one 32-bit mailbox word. The host writes a command word that carries a target address, a data byte and a direction flag. The bridge latches that word, raises a busy flag and performs a single access on the byte bank. The busy flag stays up for a fixed, parameterised number of cycles. The host polls busy before it issues a command. For a read it polls busy a second time and then takes the fetched byte from the top byte of the same word.

The byte bank lives outside the bridge. It sees an address, a write byte, one-cycle write and read strobes, and it returns a byte combinationally. Only the first `NUM_REGS` addresses are backed. Accesses above that range raise no strobe, and a read of such an address returns zero. The sequencer has three states. `ST_IDLE` waits for a command. `ST_ISSUE` is the first busy cycle, in which the strobe fires and read data is staged. `ST_HOLD` holds busy for the remaining cycles. The transitions are: accept (`ST_IDLE` to `ST_ISSUE`, on a host write strobe), launch (`ST_ISSUE` to `ST_HOLD`, unconditional) and release (`ST_HOLD` to `ST_IDLE`, when the hold counter reaches its last cycle). The staged read byte is published on release.

Top module: `indirect_reg_bridge`

## Requirements
- R1: After reset the status word reads all zeros, busy is low and neither bank strobe is active.
- R2: Command word fields are: target address in bits 7:0, write byte in bits 15:8, bit 16 = 1 for a write and 0 for a read. The status word echoes the last accepted command in bits 16:0. Bits 22:17 read zero, and bits 31:17 of a command word have no effect.
- R3: Busy (status bit 23) rises in the cycle after an accepted host write strobe and stays high for exactly `BUSY_CYCLES` clock cycles.
- R4: A write to a backed address produces exactly one bank write strobe, carrying the command's address and byte, while busy is high. A write leaves the read-data field unchanged.
- R5: A read places the fetched byte in status bits 31:24 in the first cycle that busy is low again, and not earlier. The field then holds that value until the next read completes, whatever writes occur in between.
- R6: A host write strobe while busy is high is ignored. The echoed command, the bank contents and the length of the busy period stay as they were.
- R7: An address greater than or equal to `NUM_REGS` is not backed. A write there raises no bank strobe, and a read there returns zero.
- R8: A new command is accepted in the first cycle busy is low after a previous access, so commands can follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the mailbox word |
| host_wdata | input | 32 | Command word written by the host |
| host_rdata | output | 32 | Status word: read byte, busy flag, echoed command |
| bank_addr | output | 8 | Address presented to the byte bank |
| bank_wdata | output | 8 | Byte presented for a bank write |
| bank_we | output | 1 | One-cycle bank write strobe |
| bank_re | output | 1 | One-cycle bank read strobe |
| bank_rdata | input | 8 | Byte returned by the bank for the presented address |

## Verification
The bridge gets writes and reads to backed addresses, which show that the address, byte and direction fields are routed and that the busy period has the right length. Reads of two different locations in a row separate a read field that updates on release from one that updates early or not at all. Writes and reads to unbacked addresses that alias a preloaded bank location show whether the range check gates both the strobe and the returned byte. A second strobe injected during busy shows that the command is ignored rather than extending or restarting the busy period. A command issued at the first idle sample shows that a back-to-back access is accepted.

// File: rtl/irb_pkg.sv
package irb_pkg;

    localparam int WORD_W      = 32;
    localparam int ADDR_W      = 8;
    localparam int BYTE_W      = 8;

    localparam int F_ADDR_LSB  = 0;
    localparam int F_WDATA_LSB = 8;
    localparam int F_WRITE_BIT = 16;
    localparam int F_BUSY_BIT  = 23;
    localparam int F_RDATA_LSB = 24;
    localparam int PAD_W       = F_BUSY_BIT - F_WRITE_BIT - 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_HOLD  = 2'd2
    } irb_state_e;

    typedef struct packed {
        logic              is_write;
        logic [BYTE_W-1:0] wdata;
        logic [ADDR_W-1:0] addr;
    } irb_cmd_t;

endpackage

// File: rtl/irb_cmd_latch.sv
module irb_cmd_latch
    import irb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [WORD_W-1:0] word,
    output irb_cmd_t          cmd_q
);

    irb_cmd_t cmd_d;
    logic [WORD_W-F_WRITE_BIT-2:0] spare_unused;

    assign spare_unused = word[WORD_W-1:F_WRITE_BIT+1];

    always_comb begin
        cmd_d.is_write = word[F_WRITE_BIT];
        cmd_d.wdata    = word[F_WDATA_LSB +: BYTE_W];
        cmd_d.addr     = word[F_ADDR_LSB +: ADDR_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q <= cmd_d;
        end
    end

endmodule

// File: rtl/irb_busy_timer.sv
module irb_busy_timer #(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    output logic last
);

    localparam int CNT_W = (BUSY_CYCLES > 2) ? $clog2(BUSY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BUSY_CYCLES - 1);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= RELOAD;
        end else if (step && (cnt_q != '0)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign last = (cnt_q == ONE);

    // R3: the hold counter never exceeds its reload value
    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r3_cnt_bounded: assert (cnt_q <= RELOAD)
                else $error("hold counter above reload value");
        end
    end

    // R3: a step never starts from an empty counter
    a_r3_step_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (cnt_q != '0));

endmodule

// File: rtl/irb_rd_capture.sv
module irb_rd_capture
    import irb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              backed,
    input  logic [BYTE_W-1:0] bank_rdata,
    input  logic              pub_en,
    output logic [BYTE_W-1:0] field_q
);

    logic [BYTE_W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (cap_en) begin
            stage_q <= backed ? bank_rdata : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= '0;
        end else if (pub_en) begin
            field_q <= stage_q;
        end
    end

    // R5: publishing takes the staged byte, one cycle after it was staged at earliest
    a_r5_publish_staged: assert property (@(posedge clk) disable iff (!rst_n)
        pub_en |=> (field_q == $past(stage_q)));

endmodule

// File: rtl/indirect_reg_bridge.sv
module indirect_reg_bridge
    import irb_pkg::*;
#(
    parameter int BUSY_CYCLES = 4,
    parameter int NUM_REGS    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic [7:0]  bank_addr,
    output logic [7:0]  bank_wdata,
    output logic        bank_we,
    output logic        bank_re,
    input  logic [7:0]  bank_rdata
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(NUM_REGS);

    irb_state_e        state_q;
    irb_state_e        state_d;
    irb_cmd_t          cmd_q;
    logic              accept;
    logic              backed;
    logic              busy;
    logic              cap_en;
    logic              pub_en;
    logic              load;
    logic              step;
    logic              last;
    logic [BYTE_W-1:0] rd_field;

    assign accept = host_wr && (state_q == ST_IDLE);
    assign backed = ({1'b0, cmd_q.addr} < LIMIT);

    irb_cmd_latch u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .word   (host_wdata),
        .cmd_q  (cmd_q)
    );

    irb_busy_timer #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .last  (last)
    );

    irb_rd_capture u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (cap_en),
        .backed     (backed),
        .bank_rdata (bank_rdata),
        .pub_en     (pub_en),
        .field_q    (rd_field)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (host_wr) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_HOLD;
            ST_HOLD:  if (last) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b0;
        bank_we = 1'b0;
        bank_re = 1'b0;
        cap_en  = 1'b0;
        pub_en  = 1'b0;
        load    = 1'b0;
        step    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ISSUE: begin
                busy    = 1'b1;
                load    = 1'b1;
                bank_we = cmd_q.is_write && backed;
                bank_re = !cmd_q.is_write && backed;
                cap_en  = !cmd_q.is_write;
            end
            ST_HOLD: begin
                busy   = 1'b1;
                step   = 1'b1;
                pub_en = last && !cmd_q.is_write;
            end
            default: begin
            end
        endcase
    end

    assign bank_addr  = cmd_q.addr;
    assign bank_wdata = cmd_q.wdata;
    assign host_rdata = {rd_field, busy, {PAD_W{1'b0}}, cmd_q};

    // R1: no bank strobe outside a busy period
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(bank_we || bank_re));

    // R3: an accepted strobe raises busy on the next cycle
    a_r3_busy_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !busy) |=> busy);

    // R4: a write strobe lasts one cycle and busy is still high after it
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |=> (!bank_we && busy));

    // R5: the read-data field only moves when busy falls
    a_r5_field_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_field) |-> $fell(busy));

    // R6: the latched command is frozen while busy
    a_r6_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_q));

endmodule

// File: tb/tb_indirect_reg_bridge.sv
module tb_indirect_reg_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int BUSY       = 4;
    localparam int NREG       = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [7:0]  bank_addr;
    logic [7:0]  bank_wdata;
    logic        bank_we;
    logic        bank_re;
    logic [7:0]  bank_rdata;
    logic [7:0]  regs [16];

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    indirect_reg_bridge #(
        .BUSY_CYCLES (BUSY),
        .NUM_REGS    (NREG)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .bank_addr  (bank_addr),
        .bank_wdata (bank_wdata),
        .bank_we    (bank_we),
        .bank_re    (bank_re),
        .bank_rdata (bank_rdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) regs[i] <= 8'hA0 + 8'(i);
        end else if (bank_we) begin
            regs[bank_addr[3:0]] <= bank_wdata;
        end
    end

    assign bank_rdata = regs[bank_addr[3:0]];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [7:0] addr, input logic [7:0] data,
                                       input logic wr);
        return {15'b0, wr, data, addr};
    endfunction

    // called at a negedge; returns at the negedge after the accepting edge
    task automatic send(input logic [31:0] w);
        host_wdata = w;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic wait_idle(output int n, output int we_seen);
        n = 0;
        we_seen = 0;
        while (host_rdata[23] && n < 1000) begin
            n++;
            if (bank_we) we_seen++;
            @(negedge clk);
        end
    endtask

    task automatic do_read(input logic [7:0] addr, output logic [7:0] val);
        int n, w;
        send(mk(addr, 8'h00, 1'b0));
        wait_idle(n, w);
        val = host_rdata[31:24];
    endtask

    task automatic t_reset;
        chk("R1 status word", host_rdata, 32'h0);
        chk("R1 strobes", {30'b0, bank_we, bank_re}, 32'h0);
    endtask

    task automatic t_write;
        int n, w;
        send(mk(8'h02, 8'h3C, 1'b1));
        chk("R3 busy after accept", {31'b0, host_rdata[23]}, 32'h1);
        wait_idle(n, w);
        chk("R3 busy length", n, BUSY);
        chk("R4 one write strobe", w, 1);
        chk("R2 echo write", {15'b0, host_rdata[16:0]}, {15'b0, 1'b1, 8'h3C, 8'h02});
        chk("R2 pad bits zero", {26'b0, host_rdata[22:17]}, 32'h0);
        chk("R4 read field untouched", {24'b0, host_rdata[31:24]}, 32'h0);
    endtask

    task automatic t_read;
        int n, w;
        logic [7:0] v;
        send(mk(8'h02, 8'h00, 1'b0));
        chk("R5 field not early", {24'b0, host_rdata[31:24]}, 32'h0);
        wait_idle(n, w);
        chk("R5 read back written", {24'b0, host_rdata[31:24]}, 32'h3C);
        chk("R3 read busy length", n, BUSY);
        do_read(8'h05, v);
        chk("R5 read preload", {24'b0, v}, 32'hA5);
        send(mk(8'h06, 8'h42, 1'b1));
        wait_idle(n, w);
        chk("R5 field held over write", {24'b0, host_rdata[31:24]}, 32'hA5);
        do_read(8'h06, v);
        chk("R4 write landed", {24'b0, v}, 32'h42);
    endtask

    task automatic t_unbacked;
        int n, w;
        logic [7:0] v;
        send(mk(8'h0D, 8'h77, 1'b1));
        wait_idle(n, w);
        chk("R7 no strobe unbacked", w, 0);
        do_read(8'h0D, v);
        chk("R7 unbacked reads zero", {24'b0, v}, 32'h0);
        do_read(8'h8D, v);
        chk("R7 high unbacked reads zero", {24'b0, v}, 32'h0);
        do_read(8'h0B, v);
        chk("R7 top backed address", {24'b0, v}, 32'hAB);
    endtask

    task automatic t_ignore;
        int n, w;
        logic [7:0] v;
        send(mk(8'h04, 8'h11, 1'b1));
        host_wdata = mk(8'h07, 8'hEE, 1'b1);
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
        wait_idle(n, w);
        chk("R6 busy not extended", n + 1, BUSY);
        chk("R6 echo unchanged", {15'b0, host_rdata[16:0]}, {15'b0, 1'b1, 8'h11, 8'h04});
        do_read(8'h07, v);
        chk("R6 bank untouched", {24'b0, v}, 32'hA7);
        do_read(8'h04, v);
        chk("R6 first write kept", {24'b0, v}, 32'h11);
    endtask

    task automatic t_back_to_back;
        int n, w;
        chk("R8 idle before issue", {31'b0, host_rdata[23]}, 32'h0);
        send({8'hFF, 1'b1, 6'h3F, 1'b0, 8'h99, 8'h02});
        chk("R8 accepted at once", {31'b0, host_rdata[23]}, 32'h1);
        wait_idle(n, w);
        chk("R2 upper bits ignored", {15'b0, host_rdata[16:0]}, {15'b0, 1'b0, 8'h99, 8'h02});
        chk("R2 read of addr field", {24'b0, host_rdata[31:24]}, 32'h3C);
        chk("R3 busy length b2b", n, BUSY);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_unbacked();
        t_ignore();
        t_back_to_back();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule